// File: doc/BRIEF.md
# Paging MMU Control Register File

This block holds the programming state of a paged memory-management unit and carries out register-move commands on it. Four registers are kept: a one-word translation control register, two double-word root pointers (one for supervisor accesses, one for the processor's user tables), and a status register. Each root pointer consists of a limit word and a table-address word. The most significant bit of the control register drives the translation-enable output.

The instruction front end decodes a move command and presents it for one cycle with a strobe. The command carries a move form, a register select and a direction. A load takes its operand from a double-word write port. Single-word loads use the low half of that port. A store returns the selected register on the read port in the same cycle. The effective-address logic then writes that value to memory. A command that names a form or a register the unit does not implement raises an error flag and leaves every register unchanged.

Top module: `pg_ctl_regs`

## Requirements
- R1: After synchronous reset every register reads as zero, and `xlat_en` is 0.
- R2: A load of the control register sets `xlat_en` from bit WORD_W-1 (bit 31) of the loaded word. The new value is visible in the cycle after the strobe. Every other bit of the operand has no effect on `xlat_en`.
- R3: The control register is selected by `cmd_sel`=0 in the control form. It loads from `wr_data[31:0]`. A store returns it in `rd_data[31:0]` with the upper 32 bits zero.
- R4: `cmd_sel`=2 selects the supervisor root pointer and `cmd_sel`=3 selects the user root pointer. Both are in the control form. A load puts `wr_data[63:32]` into the limit word and `wr_data[31:0]` into the table address. A store returns the limit word in the upper half and the table address in the lower half. The two pointers are independent.
- R5: Move forms 0 and 2 are both the control form, and they behave identically.
- R6: Move form 3 accesses the status register and ignores `cmd_sel`. A load keeps `wr_data[SR_W-1:0]`, with SR_W=16. A store returns that value zero-extended.
- R7: In the control form, a select of 1 or 4 to 7 asserts `cmd_err` in the strobe cycle, keeps `rd_valid` low and changes no register.
- R8: Move forms 1 and 4 to 7 assert `cmd_err` in the strobe cycle, keep `rd_valid` low and change no register.
- R9: `cmd_store`=1 selects a store and 0 selects a load. A store that is not an error drives `rd_valid` high and `rd_data` with the register in the strobe cycle. In every other cycle `rd_valid` is 0 and `rd_data` is zero.
- R10: A value loaded in one cycle is returned by a store of the same register issued in the very next cycle.
- R11: While `cmd_valid` is 0, the other command inputs have no effect on any register or on `xlat_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_form | input | 3 | Move form: 0/2 control form, 3 status form |
| cmd_sel | input | 3 | Register select in the control form |
| cmd_store | input | 1 | 1 = register to store path, 0 = load from write port |
| wr_data | input | 2*WORD_W | Load operand |
| rd_data | output | 2*WORD_W | Store data, zero when not a valid store |
| rd_valid | output | 1 | Store data valid this cycle |
| cmd_err | output | 1 | Unknown form or register select this cycle |
| xlat_en | output | 1 | Translation enable |

## Verification
The bench sweeps every combination of form, select and direction with distinct operands. It checks every strobe against an arithmetic model of the four registers. A decoder that treated only one of forms 0 and 2 as the control form would flag errors or return stale data in half of that sweep. A decoder that let an unknown select write anyway would corrupt a register, and a later store would reveal it. Swapping the root-pointer halves or the two root pointers shows up as a mismatched double word. Taking the enable from the wrong bit is caught by two operands: one with only bit 31 set, and one with every bit except bit 31 set. A read one cycle late fails the back-to-back load and store check. Commands driven without the strobe must leave every register intact.

// File: rtl/pg_ctl_pkg.sv
package pg_ctl_pkg;
  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] FORM_CTL_A = 3'd0;
  localparam logic [CMD_W-1:0] FORM_CTL_B = 3'd2;
  localparam logic [CMD_W-1:0] FORM_STAT  = 3'd3;

  localparam logic [CMD_W-1:0] SEL_TC  = 3'd0;
  localparam logic [CMD_W-1:0] SEL_SRP = 3'd2;
  localparam logic [CMD_W-1:0] SEL_CRP = 3'd3;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_TC,
    TGT_SRP,
    TGT_CRP,
    TGT_SR
  } tgt_e;
endpackage

// File: rtl/pg_ctl_decode.sv
module pg_ctl_decode
  import pg_ctl_pkg::*;
(
  input  logic             valid,
  input  logic [CMD_W-1:0] form,
  input  logic [CMD_W-1:0] sel,
  input  logic             store,
  output tgt_e             tgt,
  output logic             err,
  output logic             do_load,
  output logic             do_store
);
  always_comb begin
    tgt = TGT_NONE;
    err = 1'b0;
    if (valid) begin
      if (form == FORM_CTL_A || form == FORM_CTL_B) begin
        if (sel == SEL_TC)       tgt = TGT_TC;
        else if (sel == SEL_SRP) tgt = TGT_SRP;
        else if (sel == SEL_CRP) tgt = TGT_CRP;
        else                     err = 1'b1;
      end else if (form == FORM_STAT) begin
        tgt = TGT_SR;
      end else begin
        err = 1'b1;
      end
    end
  end

  assign do_load  = (tgt != TGT_NONE) && !store;
  assign do_store = (tgt != TGT_NONE) && store;
endmodule

// File: rtl/pg_word_reg.sv
module pg_word_reg #(
  parameter int W     = 32,
  parameter int DIN_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [DIN_W-1:0] din,
  output logic [W-1:0]     q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= din[W-1:0];
  end
endmodule

// File: rtl/pg_root_reg.sv
module pg_root_reg #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld,
  input  logic [2*WORD_W-1:0] din,
  output logic [2*WORD_W-1:0] q
);
  logic [WORD_W-1:0] limit_q;
  logic [WORD_W-1:0] taddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      taddr_q <= '0;
    end else if (ld) begin
      limit_q <= din[2*WORD_W-1:WORD_W];
      taddr_q <= din[WORD_W-1:0];
    end
  end

  assign q = {limit_q, taddr_q};
endmodule

// File: rtl/pg_ctl_regs.sv
module pg_ctl_regs
  import pg_ctl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SR_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_form,
  input  logic [2:0]          cmd_sel,
  input  logic                cmd_store,
  input  logic [2*WORD_W-1:0] wr_data,
  output logic [2*WORD_W-1:0] rd_data,
  output logic                rd_valid,
  output logic                cmd_err,
  output logic                xlat_en
);
  localparam int DATA_W = 2 * WORD_W;
  localparam int NROOT  = 2;

  tgt_e tgt;
  logic do_load, do_store;

  pg_ctl_decode u_dec (
    .valid   (cmd_valid),
    .form    (cmd_form),
    .sel     (cmd_sel),
    .store   (cmd_store),
    .tgt     (tgt),
    .err     (cmd_err),
    .do_load (do_load),
    .do_store(do_store)
  );

  logic [WORD_W-1:0] tc_q;
  logic [SR_W-1:0]   sr_q;
  logic [DATA_W-1:0] root_q [NROOT];

  pg_word_reg #(.W(WORD_W), .DIN_W(DATA_W)) u_tc (
    .clk(clk), .rst(rst), .ld(do_load && tgt == TGT_TC), .din(wr_data), .q(tc_q)
  );

  pg_word_reg #(.W(SR_W), .DIN_W(DATA_W)) u_sr (
    .clk(clk), .rst(rst), .ld(do_load && tgt == TGT_SR), .din(wr_data), .q(sr_q)
  );

  for (genvar g = 0; g < NROOT; g++) begin : g_root
    localparam tgt_e MY_TGT = (g == 0) ? TGT_SRP : TGT_CRP;
    pg_root_reg #(.WORD_W(WORD_W)) u_root (
      .clk(clk), .rst(rst), .ld(do_load && tgt == MY_TGT), .din(wr_data), .q(root_q[g])
    );
  end

  // enable register follows the top bit of each control-register load
  always_ff @(posedge clk) begin
    if (rst)                            xlat_en <= 1'b0;
    else if (do_load && tgt == TGT_TC)  xlat_en <= wr_data[WORD_W-1];
  end

  always_comb begin
    rd_data = '0;
    if (do_store) begin
      unique case (tgt)
        TGT_TC:  rd_data = {{WORD_W{1'b0}}, tc_q};
        TGT_SRP: rd_data = root_q[0];
        TGT_CRP: rd_data = root_q[1];
        TGT_SR:  rd_data = {{(DATA_W-SR_W){1'b0}}, sr_q};
        default: rd_data = '0;
      endcase
    end
  end

  assign rd_valid = do_store;
endmodule

// File: rtl/pg_ctl_regs_chk.sv
module pg_ctl_regs_chk #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic [2:0]          cmd_form,
  input logic [2:0]          cmd_sel,
  input logic                cmd_store,
  input logic [2*WORD_W-1:0] wr_data,
  input logic [2*WORD_W-1:0] rd_data,
  input logic                rd_valid,
  input logic                cmd_err,
  input logic                xlat_en
);
  logic ctl_form, bad_sel;
  assign ctl_form = (cmd_form == 3'd0) || (cmd_form == 3'd2);
  assign bad_sel  = !(cmd_sel == 3'd0 || cmd_sel == 3'd2 || cmd_sel == 3'd3);

  // R2
  tc_load_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ctl_form && cmd_sel == 3'd0 && !cmd_store) |=> (xlat_en == $past(wr_data[WORD_W-1])));

  // R7
  bad_select_err_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ctl_form && bad_sel) |-> (cmd_err && !rd_valid));

  // R8
  bad_form_err_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !ctl_form && cmd_form != 3'd3) |-> (cmd_err && !rd_valid));

  // R7
  err_keeps_enable_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> $stable(xlat_en));

  // R11
  idle_keeps_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(xlat_en));

  // R9
  read_only_on_store_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (cmd_valid && cmd_store && !cmd_err));

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));
endmodule

bind pg_ctl_regs pg_ctl_regs_chk #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_form(cmd_form),
  .cmd_sel(cmd_sel), .cmd_store(cmd_store), .wr_data(wr_data),
  .rd_data(rd_data), .rd_valid(rd_valid), .cmd_err(cmd_err), .xlat_en(xlat_en)
);

// File: tb/test_pg_ctl_regs.sv
module test_pg_ctl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_form = '0;
  logic [2:0]  cmd_sel = '0;
  logic        cmd_store = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        rd_valid, cmd_err, xlat_en;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_tc;
  logic [63:0] m_srp, m_crp;
  logic [15:0] m_sr;
  logic        m_en;

  always #5 clk = ~clk;

  pg_ctl_regs i_pg_ctl_regs (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_form(cmd_form),
    .cmd_sel(cmd_sel), .cmd_store(cmd_store), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .cmd_err(cmd_err), .xlat_en(xlat_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic m_err(input logic [2:0] f, input logic [2:0] s);
    if (f == 3'd3) return 1'b0;
    if (f == 3'd0 || f == 3'd2) return !(s == 3'd0 || s == 3'd2 || s == 3'd3);
    return 1'b1;
  endfunction

  function automatic logic [63:0] m_read(input logic [2:0] f, input logic [2:0] s);
    if (f == 3'd3) return {48'd0, m_sr};
    if (s == 3'd0) return {32'd0, m_tc};
    if (s == 3'd2) return m_srp;
    return m_crp;
  endfunction

  function automatic string tag(input logic [2:0] f, input logic [2:0] s);
    if (f != 3'd0 && f != 3'd2 && f != 3'd3) return "R8";
    if (m_err(f, s)) return "R7";
    if (f == 3'd3) return "R6";
    if (f == 3'd2) return "R5";
    if (s == 3'd0) return "R3";
    return "R4";
  endfunction

  task automatic issue(input logic [2:0] f, input logic [2:0] s, input logic st,
                       input logic [63:0] d, input string req);
    logic e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_form = f; cmd_sel = s; cmd_store = st; wr_data = d;
    #1;
    e = m_err(f, s);
    chk(req, {63'd0, cmd_err}, {63'd0, e});
    chk("R9", {63'd0, rd_valid}, {63'd0, st && !e});
    chk(req, rd_data, (st && !e) ? m_read(f, s) : 64'd0);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    if (!st && !e) begin
      if (f == 3'd3)      m_sr  = d[15:0];
      else if (s == 3'd0) begin m_tc = d[31:0]; m_en = d[31]; end
      else if (s == 3'd2) m_srp = d;
      else                m_crp = d;
    end
    chk("R2", {63'd0, xlat_en}, {63'd0, m_en});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_tc = '0; m_srp = '0; m_crp = '0; m_sr = '0; m_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state seen through every store path
    chk("R1", {63'd0, xlat_en}, 64'd0);
    issue(3'd0, 3'd0, 1'b1, '0, "R1");
    issue(3'd0, 3'd2, 1'b1, '0, "R1");
    issue(3'd0, 3'd3, 1'b1, '0, "R1");
    issue(3'd3, 3'd5, 1'b1, '0, "R1");

    // R5 R6 R7 R8 R3 R4: exhaustive form x select x direction sweep
    for (int pass = 0; pass < 2; pass++)
      for (int f = 0; f < 8; f++)
        for (int s = 0; s < 8; s++)
          for (int st = 0; st < 2; st++) begin
            logic [63:0] d;
            d = (64'h9E37_79B9_7F4A_7C15 * 64'(pass*128 + f*16 + s*2 + st + 1))
                ^ {32'(f*8+s), 32'(pass)};
            issue(3'(f), 3'(s), st[0], d, tag(3'(f), 3'(s)));
          end

    // R2: only bit 31 decides the enable
    issue(3'd0, 3'd0, 1'b0, 64'hFFFF_FFFF_8000_0000 ^ 64'hFFFF_FFFF_0000_0000, "R2");
    chk("R2", {63'd0, xlat_en}, 64'd1);
    issue(3'd2, 3'd0, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, "R2");
    chk("R2", {63'd0, xlat_en}, 64'd0);
    issue(3'd0, 3'd0, 1'b1, '0, "R3");

    // R10: back-to-back load then store of each pointer
    issue(3'd0, 3'd2, 1'b0, 64'h0123_4567_89AB_CDEF, "R10");
    issue(3'd0, 3'd2, 1'b1, '0, "R10");
    issue(3'd2, 3'd3, 1'b0, 64'hFEDC_BA98_7654_3210, "R10");
    issue(3'd0, 3'd3, 1'b1, '0, "R10");
    issue(3'd0, 3'd2, 1'b1, '0, "R4");
    issue(3'd0, 3'd0, 1'b0, 64'h0000_0000_8000_0001, "R10");
    issue(3'd0, 3'd0, 1'b1, '0, "R10");

    // R11: command fields toggling without strobe
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0; cmd_form = 3'(k % 4); cmd_sel = 3'(k % 4); cmd_store = 1'b0;
      wr_data = ~(64'h1111_1111_1111_1111 * 64'(k));
      #1;
      chk("R11", {63'd0, rd_valid}, 64'd0);
    end
    chk("R11", {63'd0, xlat_en}, {63'd0, m_en});
    issue(3'd0, 3'd0, 1'b1, '0, "R11");
    issue(3'd0, 3'd2, 1'b1, '0, "R11");
    issue(3'd2, 3'd3, 1'b1, '0, "R11");
    issue(3'd3, 3'd0, 1'b1, '0, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule